// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Front-End

This block is the host-facing register file of a small SCSI protocol controller. A byte-wide register bus reaches sixteen register slots. Each slot has two faces: a read bank that returns status and a write bank that holds what the host last wrote. The register index is the bus address shifted right by `ADDR_SHIFT`. A FIFO slot accepts host bytes. Those bytes go into a command-descriptor buffer while an outside phase engine asks for command bytes, and into a transfer buffer the rest of the time. The host reads the transfer buffer back through the same slot.

A command slot decodes controller commands. Some commands are finished locally: each loads its own fixed mix of interrupt-cause, sequence-step, flag and status values. Others are forwarded as a one-cycle pulse to the phase engine. The phase engine can also post a completion event, made of status, cause and step, through a valid/ready handshake. A single level interrupt line follows the pending bit of the status register. Reading the interrupt-cause register acknowledges the interrupt.

The design has no SCSI bus phase engine, no DMA engine and no target model. It only decodes commands and reports status.

Top module: `scsi_regfront`

## Requirements
- R1: After reset, both banks read zero except two slots: the transfer-count-high read slot (index 14) returns `CHIP_ID`, and configuration slot 1 (index 8) returns 7. The `irq` output is low.
- R2: The register index is `bus_addr >> ADDR_SHIFT`, so the address bits below the shift are ignored. Transfer-count low/middle (indices 0, 1) are held only in the write bank. Indices 8–13 and 15 read back what was written.
- R3: An access is accepted when `bus_size` is 1. A write with `bus_size` of 4 is also accepted and uses `bus_wdata[7:0]`. Any other access raises `bus_err` in that cycle, has no effect, and reads zero.
- R4: `irq` always equals status bit 7, the pending bit. It rises only through a raise event and falls only through an acknowledge or a reset.
- R5: A read of interrupt-cause (index 5) returns its old value. The same access clears that register, clears status bits 7 and 4 (terminal count), sets sequence-step (index 6) to 4, and lowers `irq`.
- R6: A FIFO write (index 2) clears status bit 4. While `cmd_collect` is high, the byte is appended to the command buffer. Otherwise, if the transfer buffer holds `XFER_DEPTH-1` bytes, the byte is dropped and status bit 6 (overrun) is set. In all other cases the byte is stored in the transfer buffer.
- R7: A FIFO read returns the oldest transfer byte and removes it. When the transfer buffer is empty, the read returns zero and changes nothing.
- R8: A command byte with bit 7 set copies write-bank indices 0 and 1 into read-bank indices 0 and 1. Command codes are taken from bits 6:0.
- R9: Flush (code 0x01) empties the transfer buffer, sets interrupt-cause to 0x08, clears sequence-step and FIFO-flags (index 7), and does not raise.
- R10: Bus reset (code 0x03) sets interrupt-cause to 0x80. It raises only when bit 6 of configuration slot 1 is clear.
- R11: Code 0x11 sets cause 0x08, sets status bits 2:0 to 7, and raises. Code 0x12 sets cause 0x20, clears sequence-step and flags, and raises. Code 0x18 sets status to 0x10, sets cause 0x08, clears sequence-step, and raises.
- R12: Codes 0x44 and 0x45 clear interrupt-cause. Codes 0x10, 0x1A, 0x1B, 0x41, 0x42 and 0x43 pulse `fwd_valid` for one cycle, with the command byte on `fwd_code`, in the cycle after the write. All other codes, including 0x00, have no effect.
- R13: Code 0x02 restores the R1 reset state of the banks, empties both buffers and lowers `irq`.
- R14: `evt_ready` is high only when no interrupt is pending and no bus access is present. When `evt_valid` and `evt_ready` are both high, status takes `evt_status` with bit 7 set, cause takes `evt_intr`, step takes `evt_seq`, and `irq` rises. Back-pressure is expressed only by `evt_ready` staying low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_size | input | 3 | Access size in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (ignored while bus_wr is high) |
| bus_wdata | input | 32 | Write data, low byte used |
| bus_rdata | output | 8 | Read data for the current access |
| bus_err | output | 1 | Access rejected |
| irq | output | 1 | Level interrupt |
| cmd_collect | input | 1 | FIFO writes feed the command buffer |
| cmd_clr | input | 1 | Empty the command buffer |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Command bytes held |
| cmd_rd_idx | input | $clog2(CMD_DEPTH) | Command buffer read index |
| cmd_rd_data | output | 8 | Command byte at cmd_rd_idx |
| fwd_valid | output | 1 | Forwarded command pulse |
| fwd_code | output | 8 | Forwarded command byte |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Completion event can be taken |
| evt_status | input | 8 | Event status value |
| evt_intr | input | 8 | Event interrupt cause |
| evt_seq | input | 8 | Event sequence step |

## Verification
The bench builds the block with `XFER_DEPTH` = 4, `CMD_DEPTH` = 4, `ADDR_SHIFT` = 2 and a distinctive `CHIP_ID`. With the shallow transfer buffer, the overrun drop happens on the fourth byte. The bench sets both address bits below the shift on every access, which shows that they are ignored. The non-default chip code shows that the identification value really reaches the transfer-count-high slot.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;
  localparam int REG_CNT = 16;
  localparam int IDX_W   = 4;

  localparam logic [IDX_W-1:0] IX_TC_LO  = 4'd0;
  localparam logic [IDX_W-1:0] IX_TC_MID = 4'd1;
  localparam logic [IDX_W-1:0] IX_FIFO   = 4'd2;
  localparam logic [IDX_W-1:0] IX_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] IX_STAT   = 4'd4;
  localparam logic [IDX_W-1:0] IX_INTR   = 4'd5;
  localparam logic [IDX_W-1:0] IX_SEQ    = 4'd6;
  localparam logic [IDX_W-1:0] IX_FLAGS  = 4'd7;
  localparam logic [IDX_W-1:0] IX_CFG1   = 4'd8;
  localparam logic [IDX_W-1:0] IX_TC_HI  = 4'd14;

  // status bit positions
  localparam int ST_IRQ  = 7;
  localparam int ST_OVR  = 6;
  localparam int ST_TC   = 4;
  localparam logic [2:0] PHASE_MSG_IN = 3'b111;

  // interrupt causes
  localparam logic [7:0] CAUSE_FDONE = 8'h08;
  localparam logic [7:0] CAUSE_DISC  = 8'h20;
  localparam logic [7:0] CAUSE_BRST  = 8'h80;

  localparam logic [7:0] STEP_DONE   = 8'h04;
  localparam logic [7:0] CFG1_RESET  = 8'h07;
  localparam int         CFG1_NORPT  = 6;

  // command codes (bits 6:0)
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIPRST  = 7'h02;
  localparam logic [6:0] OP_BUSRST   = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_STEPS    = 7'h11;
  localparam logic [6:0] OP_MSGOK    = 7'h12;
  localparam logic [6:0] OP_PAD      = 7'h18;
  localparam logic [6:0] OP_ATN_ON   = 7'h1A;
  localparam logic [6:0] OP_ATN_OFF  = 7'h1B;
  localparam logic [6:0] OP_SEL      = 7'h41;
  localparam logic [6:0] OP_SEL_ATN  = 7'h42;
  localparam logic [6:0] OP_SEL_STOP = 7'h43;
  localparam logic [6:0] OP_RSEL_ON  = 7'h44;
  localparam logic [6:0] OP_RSEL_OFF = 7'h45;

  typedef struct packed {
    logic       load_intr;
    logic [7:0] intr;
    logic       clr_seq;
    logic       clr_flags;
    logic       stat_tc_only;
    logic       stat_msg_in;
    logic       raise;
    logic       flush;
    logic       chip_reset;
    logic       forward;
  } cmd_fx_t;
endpackage

// File: rtl/scsi_rf_cmd_decode.sv
module scsi_rf_cmd_decode
  import scsi_rf_pkg::*;
(
  input  logic [6:0] op,
  input  logic       rpt_off,
  output cmd_fx_t    fx
);
  always_comb begin
    fx = '0;
    case (op)
      OP_FLUSH: begin
        fx.load_intr = 1'b1;
        fx.intr      = CAUSE_FDONE;
        fx.clr_seq   = 1'b1;
        fx.clr_flags = 1'b1;
        fx.flush     = 1'b1;
      end
      OP_CHIPRST: fx.chip_reset = 1'b1;
      OP_BUSRST: begin
        fx.load_intr = 1'b1;
        fx.intr      = CAUSE_BRST;
        fx.raise     = !rpt_off;
      end
      OP_STEPS: begin
        fx.load_intr   = 1'b1;
        fx.intr        = CAUSE_FDONE;
        fx.stat_msg_in = 1'b1;
        fx.raise       = 1'b1;
      end
      OP_MSGOK: begin
        fx.load_intr = 1'b1;
        fx.intr      = CAUSE_DISC;
        fx.clr_seq   = 1'b1;
        fx.clr_flags = 1'b1;
        fx.raise     = 1'b1;
      end
      OP_PAD: begin
        fx.load_intr    = 1'b1;
        fx.intr         = CAUSE_FDONE;
        fx.clr_seq      = 1'b1;
        fx.stat_tc_only = 1'b1;
        fx.raise        = 1'b1;
      end
      OP_RSEL_ON, OP_RSEL_OFF: begin
        fx.load_intr = 1'b1;
        fx.intr      = 8'h00;
      end
      OP_XFER, OP_ATN_ON, OP_ATN_OFF, OP_SEL, OP_SEL_ATN, OP_SEL_STOP:
        fx.forward = 1'b1;
      default: fx = '0;
    endcase
  end
endmodule

// File: rtl/scsi_rf_xfer_buf.sv
module scsi_rf_xfer_buf #(
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] cnt,
  output logic             drop
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign drop    = push && (cnt == CNT_W'(DEPTH - 1));
  assign do_push = push && !drop;
  assign do_pop  = pop && (cnt != '0);
  assign head    = mem[rp];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH - 1)); // R6
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr && cnt == '0) |=> cnt == '0); // R7
endmodule

// File: rtl/scsi_rf_cmd_buf.sv
module scsi_rf_cmd_buf #(
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] len
);
  logic [7:0] mem [DEPTH];
  logic       take;

  assign take    = push && (len < CNT_W'(DEPTH));
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (take && !clr) mem[PTR_W'(len)] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) len <= '0;
    else if (take)     len <= len + 1'b1;
  end

  AST_CMD_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    len <= CNT_W'(DEPTH)); // R6
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
  import scsi_rf_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          ADDR_SHIFT = 2,
  parameter int          XFER_DEPTH = 16,
  parameter int          CMD_DEPTH  = 16,
  parameter logic [7:0]  CHIP_ID    = 8'h12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [2:0]                     bus_size,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [31:0]                    bus_wdata,
  output logic [7:0]                     bus_rdata,
  output logic                           bus_err,
  output logic                           irq,
  input  logic                           cmd_collect,
  input  logic                           cmd_clr,
  output logic [$clog2(CMD_DEPTH+1)-1:0] cmd_len,
  input  logic [$clog2(CMD_DEPTH)-1:0]   cmd_rd_idx,
  output logic [7:0]                     cmd_rd_data,
  output logic                           fwd_valid,
  output logic [7:0]                     fwd_code,
  input  logic                           evt_valid,
  output logic                           evt_ready,
  input  logic [7:0]                     evt_status,
  input  logic [7:0]                     evt_intr,
  input  logic [7:0]                     evt_seq
);
  localparam int XCNT_W = $clog2(XFER_DEPTH + 1);

  logic [7:0] rbank [REG_CNT];
  logic [7:0] wbank [REG_CNT];
  logic       irq_q;

  logic [IDX_W-1:0] idx;
  logic             size_ok, wr_go, rd_go, ack, evt_go;
  logic [7:0]       wbyte;
  logic             fifo_wr, cmd_wr, fifo_rd;
  cmd_fx_t          fx;
  logic [7:0]       cmd_stat;
  logic [7:0]       x_head;
  logic [XCNT_W-1:0] x_cnt;
  logic             x_drop, x_clr, c_clr;
  logic             unused_hi;

  assign idx       = IDX_W'(bus_addr >> ADDR_SHIFT);
  assign size_ok   = (bus_size == 3'd1) || (bus_wr && bus_size == 3'd4);
  assign wr_go     = bus_wr && size_ok;
  assign rd_go     = bus_rd && !bus_wr && size_ok;
  assign bus_err   = (bus_wr || bus_rd) && !size_ok;
  assign wbyte     = bus_wdata[7:0];
  assign unused_hi = ^bus_wdata[31:8];
  assign fifo_wr   = wr_go && idx == IX_FIFO;
  assign cmd_wr    = wr_go && idx == IX_CMD;
  assign fifo_rd   = rd_go && idx == IX_FIFO;
  assign ack       = rd_go && idx == IX_INTR;
  assign evt_ready = !irq_q && !bus_wr && !bus_rd;
  assign evt_go    = evt_valid && evt_ready;
  assign irq       = irq_q;
  assign x_clr     = cmd_wr && (fx.flush || fx.chip_reset);
  assign c_clr     = cmd_clr || (cmd_wr && fx.chip_reset);

  scsi_rf_cmd_decode u_dec (
    .op      (wbyte[6:0]),
    .rpt_off (rbank[IX_CFG1][CFG1_NORPT]),
    .fx      (fx)
  );

  scsi_rf_xfer_buf #(.DEPTH(XFER_DEPTH)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (x_clr),
    .push      (fifo_wr && !cmd_collect),
    .push_data (wbyte),
    .pop       (fifo_rd),
    .head      (x_head),
    .cnt       (x_cnt),
    .drop      (x_drop)
  );

  scsi_rf_cmd_buf #(.DEPTH(CMD_DEPTH)) u_cbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (c_clr),
    .push      (fifo_wr && cmd_collect),
    .push_data (wbyte),
    .rd_idx    (cmd_rd_idx),
    .rd_data   (cmd_rd_data),
    .len       (cmd_len)
  );

  // read data: value before this access takes effect
  always_comb begin
    bus_rdata = 8'h00;
    if (rd_go) begin
      if (idx == IX_FIFO) bus_rdata = (x_cnt != '0) ? x_head : 8'h00;
      else                bus_rdata = rbank[idx];
    end
  end

  // status produced by a locally completed command
  always_comb begin
    cmd_stat = rbank[IX_STAT];
    if (fx.stat_tc_only) cmd_stat = 8'(1 << ST_TC);
    if (fx.stat_msg_in)  cmd_stat[2:0] = PHASE_MSG_IN;
    if (fx.raise)        cmd_stat[ST_IRQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) begin
        rbank[i] <= 8'h00;
        wbank[i] <= 8'h00;
      end
      rbank[IX_TC_HI] <= CHIP_ID;
      rbank[IX_CFG1]  <= CFG1_RESET;
      wbank[IX_CFG1]  <= CFG1_RESET;
      irq_q     <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_code  <= 8'h00;
    end else begin
      fwd_valid <= 1'b0;
      if (wr_go) begin
        wbank[idx] <= wbyte;
        case (idx)
          IX_FIFO: begin
            rbank[IX_STAT][ST_TC] <= 1'b0;
            if (x_drop && !cmd_collect) rbank[IX_STAT][ST_OVR] <= 1'b1;
          end
          IX_CMD: begin
            rbank[IX_CMD] <= wbyte;
            if (wbyte[7]) begin
              rbank[IX_TC_LO]  <= wbank[IX_TC_LO];
              rbank[IX_TC_MID] <= wbank[IX_TC_MID];
            end
            rbank[IX_STAT] <= cmd_stat;
            if (fx.raise)     irq_q <= 1'b1;
            if (fx.load_intr) rbank[IX_INTR]  <= fx.intr;
            if (fx.clr_seq)   rbank[IX_SEQ]   <= 8'h00;
            if (fx.clr_flags) rbank[IX_FLAGS] <= 8'h00;
            if (fx.forward) begin
              fwd_valid <= 1'b1;
              fwd_code  <= wbyte;
            end
            if (fx.chip_reset) begin
              for (int i = 0; i < REG_CNT; i++) begin
                rbank[i] <= 8'h00;
                wbank[i] <= 8'h00;
              end
              rbank[IX_TC_HI] <= CHIP_ID;
              rbank[IX_CFG1]  <= CFG1_RESET;
              wbank[IX_CFG1]  <= CFG1_RESET;
              irq_q <= 1'b0;
            end
          end
          IX_TC_LO, IX_TC_MID, IX_TC_HI, IX_STAT, IX_INTR, IX_SEQ, IX_FLAGS: ;
          default: rbank[idx] <= wbyte;
        endcase
      end else if (ack) begin
        rbank[IX_INTR]         <= 8'h00;
        rbank[IX_STAT][ST_IRQ] <= 1'b0;
        rbank[IX_STAT][ST_TC]  <= 1'b0;
        rbank[IX_SEQ]          <= STEP_DONE;
        irq_q                  <= 1'b0;
      end else if (evt_go) begin
        rbank[IX_STAT] <= evt_status | 8'(1 << ST_IRQ);
        rbank[IX_INTR] <= evt_intr;
        rbank[IX_SEQ]  <= evt_seq;
        irq_q          <= 1'b1;
      end
    end
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == rbank[IX_STAT][ST_IRQ]); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!irq_q && rbank[IX_INTR] == 8'h00 && rbank[IX_SEQ] == STEP_DONE)); // R5
  AST_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready |-> !irq); // R14
  AST_EVT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_go |=> irq); // R14
  AST_REJECT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> ($stable(rbank[IX_CFG1]) && $stable(irq_q))); // R3
  AST_FWD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !cmd_wr) |=> !fwd_valid); // R12
endmodule

// File: tb/sim_scsi_regfront.sv
module sim_scsi_regfront;
  localparam int CLK_P = 10;
  localparam int NV    = 58;
  localparam logic [1:0] W = 2'd0, RD = 2'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_err, irq;
  logic        cmd_collect = 1'b0, cmd_clr = 1'b0;
  logic [2:0]  cmd_len;
  logic [1:0]  cmd_rd_idx = '0;
  logic [7:0]  cmd_rd_data;
  logic        fwd_valid;
  logic [7:0]  fwd_code;
  logic        evt_valid = 1'b0, evt_ready;
  logic [7:0]  evt_status = '0, evt_intr = '0, evt_seq = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  scsi_regfront #(.ADDR_W(8), .ADDR_SHIFT(2), .XFER_DEPTH(4), .CMD_DEPTH(4),
                  .CHIP_ID(8'hA5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq),
    .cmd_collect(cmd_collect), .cmd_clr(cmd_clr), .cmd_len(cmd_len),
    .cmd_rd_idx(cmd_rd_idx), .cmd_rd_data(cmd_rd_data),
    .fwd_valid(fwd_valid), .fwd_code(fwd_code), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_status(evt_status), .evt_intr(evt_intr),
    .evt_seq(evt_seq));

  // {op, index, data or expected, requirement number}
  localparam logic [19:0] VEC [NV] = '{
    {RD,4'd14,8'hA5,6'd1}, {RD,4'd8,8'h07,6'd1},  {RD,4'd4,8'h00,6'd1},  {RD,4'd5,8'h00,6'd1},  // R1
    {W,4'd0,8'h34,6'd8},   {W,4'd1,8'h12,6'd8},   {RD,4'd0,8'h00,6'd2},  {W,4'd3,8'h80,6'd8},   // R2 R8
    {RD,4'd0,8'h34,6'd8},  {RD,4'd1,8'h12,6'd8},  {W,4'd9,8'h5A,6'd2},   {RD,4'd9,8'h5A,6'd2},  // R8 R2
    {W,4'd2,8'h11,6'd6},   {W,4'd2,8'h22,6'd6},   {W,4'd2,8'h33,6'd6},   {W,4'd2,8'h44,6'd6},   // R6
    {RD,4'd4,8'h40,6'd6},  {RD,4'd2,8'h11,6'd7},  {RD,4'd2,8'h22,6'd7},  {RD,4'd2,8'h33,6'd7},  // R6 R7
    {RD,4'd2,8'h00,6'd7},  {W,4'd3,8'h11,6'd11},  {RD,4'd4,8'hC7,6'd11}, {RD,4'd5,8'h08,6'd5},  // R7 R11 R5
    {RD,4'd4,8'h47,6'd5},  {RD,4'd6,8'h04,6'd5},  {RD,4'd5,8'h00,6'd5},  {W,4'd3,8'h18,6'd11},  // R5 R11
    {RD,4'd6,8'h00,6'd11}, {RD,4'd4,8'h90,6'd11}, {RD,4'd5,8'h08,6'd11}, {RD,4'd4,8'h00,6'd5},
    {RD,4'd6,8'h04,6'd5},  {W,4'd3,8'h12,6'd11},  {RD,4'd6,8'h00,6'd11}, {RD,4'd4,8'h80,6'd11},
    {RD,4'd5,8'h20,6'd11}, {W,4'd3,8'h03,6'd10},  {RD,4'd4,8'h80,6'd10}, {RD,4'd5,8'h80,6'd10}, // R10
    {W,4'd8,8'h47,6'd10},  {W,4'd3,8'h03,6'd10},  {RD,4'd4,8'h00,6'd10}, {W,4'd3,8'h44,6'd12},  // R12
    {RD,4'd5,8'h00,6'd12}, {W,4'd3,8'h03,6'd12},  {W,4'd3,8'h45,6'd12},  {RD,4'd5,8'h00,6'd12},
    {W,4'd3,8'h7F,6'd12},  {RD,4'd6,8'h04,6'd12}, {RD,4'd4,8'h00,6'd12}, {W,4'd2,8'h66,6'd9},   // R9
    {W,4'd3,8'h01,6'd9},   {RD,4'd2,8'h00,6'd9},  {RD,4'd6,8'h00,6'd9},  {RD,4'd4,8'h00,6'd9},
    {RD,4'd5,8'h08,6'd9},  {RD,4'd8,8'h47,6'd2}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // low address bits set on purpose: they must be dropped by the shift (R2)
  task automatic acc(input logic w, input logic [3:0] ix, input logic [31:0] d,
                     input logic [2:0] sz, output logic [7:0] rdv, output logic errv);
    @(negedge clk);
    bus_wr = w; bus_rd = !w; bus_addr = {2'b00, ix, 2'b11};
    bus_wdata = d; bus_size = sz;
    #1;
    rdv = bus_rdata; errv = bus_err;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 3'd1;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    logic       ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R14 ready idle", evt_ready, 1);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][19:18] == W, VEC[i][17:14], {24'h0, VEC[i][13:6]}, 3'd1, rv, ev);
      if (VEC[i][19:18] == RD)
        chk($sformatf("R%0d vec%0d", VEC[i][5:0], i), rv, VEC[i][13:6]);
    end

    // R14 event handshake and R4 irq tracking
    @(negedge clk);
    evt_valid = 1'b1; evt_status = 8'h13; evt_intr = 8'h10; evt_seq = 8'h02;
    #1 chk("R14 ready", evt_ready, 1);
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R4 irq up", irq, 1);
    acc(1'b0, 4'd4, 0, 3'd1, rv, ev); chk("R14 status", rv, 8'h93);
    acc(1'b0, 4'd6, 0, 3'd1, rv, ev); chk("R14 seq", rv, 8'h02);
    @(negedge clk);
    evt_valid = 1'b1;
    #1 chk("R14 ready blocked", evt_ready, 0);
    @(negedge clk);
    evt_valid = 1'b0;
    acc(1'b0, 4'd5, 0, 3'd1, rv, ev); chk("R14 cause", rv, 8'h10);
    chk("R4 irq down", irq, 0);

    // R3 access sizes
    acc(1'b1, 4'd8, 32'h11, 3'd2, rv, ev); chk("R3 err w2", ev, 1);
    acc(1'b0, 4'd8, 0, 3'd1, rv, ev);      chk("R3 no effect", rv, 8'h47);
    acc(1'b1, 4'd8, 32'hFFFF_FF21, 3'd4, rv, ev); chk("R3 w4 ok", ev, 0);
    acc(1'b0, 4'd8, 0, 3'd1, rv, ev);      chk("R3 low byte", rv, 8'h21);
    acc(1'b0, 4'd8, 0, 3'd4, rv, ev);      chk("R3 err r4", ev, 1);
    chk("R3 r4 data", rv, 8'h00);

    // R12 forwarded command
    acc(1'b1, 4'd3, 32'hC2, 3'd1, rv, ev);
    chk("R12 fwd valid", fwd_valid, 1);
    chk("R12 fwd code", fwd_code, 8'hC2);
    @(negedge clk);
    chk("R12 fwd pulse", fwd_valid, 0);

    // R6 command collection
    cmd_collect = 1'b1;
    acc(1'b1, 4'd2, 32'hAA, 3'd1, rv, ev);
    acc(1'b1, 4'd2, 32'hBB, 3'd1, rv, ev);
    cmd_collect = 1'b0;
    chk("R6 cmd len", cmd_len, 2);
    cmd_rd_idx = 2'd1;
    #1 chk("R6 cmd byte", cmd_rd_data, 8'hBB);
    acc(1'b0, 4'd2, 0, 3'd1, rv, ev); chk("R6 xfer untouched", rv, 8'h00);
    @(negedge clk); cmd_clr = 1'b1;
    @(negedge clk); cmd_clr = 1'b0;
    chk("R6 cmd clr", cmd_len, 0);

    // R13 chip reset command
    acc(1'b1, 4'd3, 32'h11, 3'd1, rv, ev);
    chk("R13 pre irq", irq, 1);
    acc(1'b1, 4'd3, 32'h02, 3'd1, rv, ev);
    chk("R13 irq", irq, 0);
    acc(1'b0, 4'd8, 0, 3'd1, rv, ev);  chk("R13 cfg1", rv, 8'h07);
    acc(1'b0, 4'd14, 0, 3'd1, rv, ev); chk("R13 id", rv, 8'hA5);
    acc(1'b0, 4'd0, 0, 3'd1, rv, ev);  chk("R13 tc", rv, 8'h00);
    acc(1'b0, 4'd5, 0, 3'd1, rv, ev);  chk("R13 cause", rv, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule